// File: doc/BRIEF.md
# Observation Dispatcher for a Handler Unit Array

This block sits between a queue of filtered memory-event observations and an array of small handler units that compute prefetch addresses. When at least one unit is free, it accepts the observation at the head of the queue. It looks up a kernel entry point by the observation's address range and event kind, and picks the free unit with the lowest index. It powers that unit up and, one cycle later, wakes it with the entry point and the observation payload. The unit stays powered until it returns a done pulse. Observations whose table entry is not valid are consumed and dropped, and no unit wakes for them.

The units return prefetch addresses over one push port per unit. An arbiter admits at most one push per cycle, lowest index first, into a 16-entry request queue. Units whose push is not admitted are stalled. The queue hands one address to the L1 data cache on each cycle in which the cache reports a spare slot.

The dispatcher is a two-state machine. In `DSP_IDLE` it can accept an observation. The transition *dispatch* (accept with a valid table entry) moves it to `DSP_WAKE`. The transition *discard* (accept with an invalid entry) and the idle self-loop keep it in `DSP_IDLE`. `DSP_WAKE` drives the wake pulse and always returns to `DSP_IDLE` through the transition *issue*.

Top module: `obs_dispatch`

## Requirements
- R1: After reset every unit is powered down, no wake pulse is driven, the request queue is empty (`pf_issue_valid` low even with `l1_spare` high), and `obs_ready` is high.
- R2: `obs_ready` is high only in `DSP_IDLE` with at least one unit not busy. When all units are busy, an offered observation is not accepted.
- R3: An accepted observation is assigned to the not-busy unit with the lowest index. The wake vector is one-hot or zero.
- R4: On the cycle after a dispatch, `unit_wake` pulses for exactly one cycle for the chosen unit. `unit_entry` then carries the table entry for (range, event) and `unit_data` carries the observation payload.
- R5: An accepted observation whose table slot is invalid, or whose event code is 3, is consumed without a wake pulse and without changing `unit_power`.
- R6: A unit's `unit_power` bit rises only through a dispatch and falls on the edge that samples its `unit_done` pulse. The unit can be dispatched again in the cycle after that pulse.
- R7: Among units raising `unit_pf_valid`, only the lowest index is admitted to the queue in a cycle. Every other requesting unit sees `unit_pf_stall` high. When the queue holds 16 entries, every requester is stalled.
- R8: The request queue is first-in first-out with 16 entries. `pf_issue_valid` is high exactly when `l1_spare` is high and the queue is non-empty. That cycle pops the head, which is shown on `pf_issue_addr`.
- R9: A table write with `tbl_we` sets the slot for (`tbl_range`, `tbl_event`) to `tbl_valid`/`tbl_entry`. Event codes are 0 demand load, 1 load fill and 2 prefetch fill. All slots reset to invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | Observation offered at queue head |
| obs_range | input | 2 | Matched address range ID |
| obs_event | input | 2 | Event kind (0 load, 1 load fill, 2 prefetch fill) |
| obs_data | input | 32 | Observation payload (address or line data) |
| obs_ready | output | 1 | Observation taken on this cycle when valid |
| tbl_we | input | 1 | Kernel table write strobe |
| tbl_range | input | 2 | Range index of written slot |
| tbl_event | input | 2 | Event index of written slot |
| tbl_valid | input | 1 | Valid flag written into slot |
| tbl_entry | input | 16 | Entry point written into slot |
| unit_power | output | 12 | Per-unit power enable (busy) |
| unit_wake | output | 12 | One-cycle start pulse per unit |
| unit_entry | output | 16 | Kernel entry point for the woken unit |
| unit_data | output | 32 | Observation payload for the woken unit |
| unit_done | input | 12 | Per-unit completion pulse |
| unit_pf_valid | input | 12 | Per-unit prefetch push request |
| unit_pf_addr | input | 384 | Per-unit prefetch address, unit i at bits [32i+31:32i] |
| unit_pf_stall | output | 12 | Per-unit push not admitted this cycle |
| l1_spare | input | 1 | L1 has a spare slot this cycle |
| pf_issue_valid | output | 1 | Prefetch address handed to L1 |
| pf_issue_addr | output | 32 | Prefetch address at queue head |

## Verification
A busy bit that is stuck or lost shows at the ports within one cycle, either as a wake pulse for the wrong unit index or as `obs_ready` staying low with units free. A table slot that is corrupted shows on `unit_entry` on the wake cycle of the next observation that hits that slot. A queue pointer or count that is off shows as a wrong `pf_issue_addr` on the next spare cycle, or as stalls that begin too early or too late around the 16-entry boundary. The sweeps fill the array one unit at a time and empty it again. They walk the queue through empty, full and simultaneous push/pop, so each of these faults surfaces within a few cycles of being caused.

// File: rtl/odp_pkg.sv
package odp_pkg;

    typedef enum logic {
        DSP_IDLE = 1'b0,
        DSP_WAKE = 1'b1
    } dsp_state_e;

    localparam int EVT_DEMAND_LOAD = 0;
    localparam int EVT_LOAD_FILL   = 1;
    localparam int EVT_PF_FILL     = 2;

endpackage

// File: rtl/odp_lowest_pick.sv
module odp_lowest_pick #(
    parameter int N = 12
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/odp_kernel_table.sv
module odp_kernel_table #(
    parameter int NR    = 4,
    parameter int NE    = 3,
    parameter int EW    = 16,
    parameter int RW    = 2,
    parameter int EVW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [RW-1:0]  wr_range,
    input  logic [EVW-1:0] wr_event,
    input  logic           wr_valid,
    input  logic [EW-1:0]  wr_entry,
    input  logic [RW-1:0]  rd_range,
    input  logic [EVW-1:0] rd_event,
    output logic           rd_hit,
    output logic [EW-1:0]  rd_entry
);

    localparam int SLOTS = NR * NE;

    logic [EW-1:0]    ent_q [SLOTS];
    logic [SLOTS-1:0] vld_q;

    int wr_slot;
    int rd_slot;
    logic wr_ok;
    logic rd_ok;

    always_comb begin
        wr_slot = int'(wr_range) * NE + int'(wr_event);
        rd_slot = int'(rd_range) * NE + int'(rd_event);
        wr_ok   = (int'(wr_event) < NE) && (int'(wr_range) < NR);
        rd_ok   = (int'(rd_event) < NE) && (int'(rd_range) < NR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < SLOTS; s++) ent_q[s] <= '0;
        end else if (wr_en && wr_ok) begin
            vld_q[wr_slot] <= wr_valid;
            ent_q[wr_slot] <= wr_entry;
        end
    end

    always_comb begin
        rd_hit   = 1'b0;
        rd_entry = '0;
        if (rd_ok) begin
            rd_hit   = vld_q[rd_slot];
            rd_entry = ent_q[rd_slot];
        end
    end

endmodule

// File: rtl/odp_push_arb.sv
module odp_push_arb #(
    parameter int NU = 12,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NU-1:0]   req,
    input  logic [NU*AW-1:0] addr,
    input  logic            q_full,
    output logic            push,
    output logic [AW-1:0]   push_addr,
    output logic [NU-1:0]   stall
);

    logic [NU-1:0] pick;
    logic [NU-1:0] grant;
    logic          pick_any;

    odp_lowest_pick #(.N(NU)) u_pick (
        .req   (req),
        .grant (pick),
        .any   (pick_any)
    );

    always_comb begin
        grant     = q_full ? '0 : pick;
        push      = pick_any && !q_full;
        stall     = req & ~grant;
        push_addr = '0;
        for (int i = 0; i < NU; i++) begin
            if (grant[i]) push_addr = push_addr | addr[i*AW +: AW];
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req & ~stall)); // R7
    AST_FULL_STALLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> (stall == req)); // R7

endmodule

// File: rtl/odp_pf_queue.sv
module odp_pf_queue #(
    parameter int DEPTH = 16,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          spare,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full      = (int'(cnt_q) == DEPTH);
        pop       = spare && (cnt_q != '0);
        out_valid = pop;
        out_addr  = mem_q[rd_q];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_addr;
                wr_q        <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= DEPTH); // R8
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push); // R7
    AST_POP_NEEDS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> spare); // R8

endmodule

// File: rtl/obs_dispatch.sv
module obs_dispatch
    import odp_pkg::*;
#(
    parameter int NU    = 12,
    parameter int NR    = 4,
    parameter int NE    = 3,
    parameter int AW    = 32,
    parameter int EW    = 16,
    parameter int QD    = 16,
    localparam int RW   = (NR > 1) ? $clog2(NR) : 1,
    localparam int EVW  = $clog2(NE + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             obs_valid,
    input  logic [RW-1:0]    obs_range,
    input  logic [EVW-1:0]   obs_event,
    input  logic [AW-1:0]    obs_data,
    output logic             obs_ready,
    input  logic             tbl_we,
    input  logic [RW-1:0]    tbl_range,
    input  logic [EVW-1:0]   tbl_event,
    input  logic             tbl_valid,
    input  logic [EW-1:0]    tbl_entry,
    output logic [NU-1:0]    unit_power,
    output logic [NU-1:0]    unit_wake,
    output logic [EW-1:0]    unit_entry,
    output logic [AW-1:0]    unit_data,
    input  logic [NU-1:0]    unit_done,
    input  logic [NU-1:0]    unit_pf_valid,
    input  logic [NU*AW-1:0] unit_pf_addr,
    output logic [NU-1:0]    unit_pf_stall,
    input  logic             l1_spare,
    output logic             pf_issue_valid,
    output logic [AW-1:0]    pf_issue_addr
);

    dsp_state_e    state_q, state_d;
    logic [NU-1:0] busy_q, busy_d;
    logic [NU-1:0] tgt_q;
    logic [EW-1:0] entry_q;
    logic [AW-1:0] data_q;

    logic [NU-1:0] free_pick;
    logic          free_any;
    logic          tbl_hit;
    logic [EW-1:0] tbl_rd_entry;
    logic          accept, dispatch;

    logic          q_push, q_full;
    logic [AW-1:0] q_push_addr;

    odp_lowest_pick #(.N(NU)) u_free (
        .req   (~busy_q),
        .grant (free_pick),
        .any   (free_any)
    );

    odp_kernel_table #(.NR(NR), .NE(NE), .EW(EW), .RW(RW), .EVW(EVW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_range (tbl_range),
        .wr_event (tbl_event),
        .wr_valid (tbl_valid),
        .wr_entry (tbl_entry),
        .rd_range (obs_range),
        .rd_event (obs_event),
        .rd_hit   (tbl_hit),
        .rd_entry (tbl_rd_entry)
    );

    // Dispatch decision and next state
    always_comb begin
        obs_ready = (state_q == DSP_IDLE) && free_any;
        accept    = obs_valid && obs_ready;
        dispatch  = accept && tbl_hit;
        state_d   = state_q;
        unique case (state_q)
            DSP_IDLE: if (dispatch) state_d = DSP_WAKE;
            DSP_WAKE: state_d = DSP_IDLE;
        endcase
        busy_d = (busy_q & ~unit_done) | (dispatch ? free_pick : '0);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DSP_IDLE;
            busy_q  <= '0;
            tgt_q   <= '0;
            entry_q <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            busy_q  <= busy_d;
            if (dispatch) begin
                tgt_q   <= free_pick;
                entry_q <= tbl_rd_entry;
                data_q  <= obs_data;
            end
        end
    end

    // Outputs
    always_comb begin
        unit_power = busy_q;
        unit_entry = entry_q;
        unit_data  = data_q;
        unique case (state_q)
            DSP_IDLE: unit_wake = '0;
            DSP_WAKE: unit_wake = tgt_q;
        endcase
    end

    odp_push_arb #(.NU(NU), .AW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (unit_pf_valid),
        .addr      (unit_pf_addr),
        .q_full    (q_full),
        .push      (q_push),
        .push_addr (q_push_addr),
        .stall     (unit_pf_stall)
    );

    odp_pf_queue #(.DEPTH(QD), .AW(AW)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (q_push_addr),
        .spare     (l1_spare),
        .out_valid (pf_issue_valid),
        .out_addr  (pf_issue_addr),
        .full      (q_full)
    );

    AST_NO_ACCEPT_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (&unit_power) |-> !obs_ready); // R2
    AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(unit_wake)); // R3
    AST_WAKE_FOLLOWS_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |=> (unit_wake != '0)); // R4
    AST_DISCARD_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tbl_hit) |=> (unit_wake == '0)); // R5
    AST_WAKE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_wake != '0) |-> ((unit_wake & ~unit_power) == '0)); // R6
    AST_POWER_RISE_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((unit_power & ~$past(unit_power)) != '0) |-> $past(dispatch)); // R6

endmodule

// File: tb/sim_obs_dispatch.sv
module sim_obs_dispatch;

    localparam int NU = 12;
    localparam int AW = 32;
    localparam int EW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             obs_valid = 0;
    logic [1:0]       obs_range = 0;
    logic [1:0]       obs_event = 0;
    logic [AW-1:0]    obs_data = 0;
    logic             obs_ready;
    logic             tbl_we = 0;
    logic [1:0]       tbl_range = 0;
    logic [1:0]       tbl_event = 0;
    logic             tbl_valid = 0;
    logic [EW-1:0]    tbl_entry = 0;
    logic [NU-1:0]    unit_power, unit_wake, unit_pf_stall;
    logic [EW-1:0]    unit_entry;
    logic [AW-1:0]    unit_data;
    logic [NU-1:0]    unit_done = 0;
    logic [NU-1:0]    unit_pf_valid = 0;
    logic [NU*AW-1:0] unit_pf_addr = 0;
    logic             l1_spare = 0;
    logic             pf_issue_valid;
    logic [AW-1:0]    pf_issue_addr;

    obs_dispatch u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [AW-1:0] mq [$];
    logic [NU-1:0] pending;
    int round_no;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [NU-1:0] m);
        for (int i = 0; i < NU; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic logic [AW-1:0] pf_addr_of(input int rnd, input int u);
        return 32'h1000_0000 + 32'(rnd * 256 + u * 4);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_tbl(input int r, input int e, input bit v, input int ent);
        tbl_we = 1; tbl_range = 2'(r); tbl_event = 2'(e);
        tbl_valid = v; tbl_entry = EW'(ent);
        tick();
        tbl_we = 0;
    endtask

    // Offer one observation; expect a wake for exp_unit or a discard (exp_unit = -1).
    task automatic offer(input int r, input int e, input logic [AW-1:0] d,
                         input int exp_unit, input int exp_entry, input string req);
        logic [NU-1:0] pw_before;
        pw_before = unit_power;
        obs_valid = 1; obs_range = 2'(r); obs_event = 2'(e); obs_data = d;
        #1;
        chk(obs_ready == 1'b1, "R2", "ready with free unit", obs_ready, 1);
        tick();
        obs_valid = 0;
        #1;
        if (exp_unit < 0) begin
            chk(unit_wake == '0, req, "no wake on discard", unit_wake, 0);
            chk(unit_power == pw_before, req, "power unchanged on discard", unit_power, pw_before);
        end else begin
            chk(unit_wake == NU'(1) << exp_unit, req, "wake target", unit_wake, NU'(1) << exp_unit);
            chk(unit_entry == EW'(exp_entry), req, "entry point", unit_entry, exp_entry);
            chk(unit_data == d, "R4", "payload", unit_data, d);
            chk(unit_power == (pw_before | (NU'(1) << exp_unit)), "R6", "power on dispatch",
                unit_power, pw_before | (NU'(1) << exp_unit));
        end
        tick();
        #1;
        chk(unit_wake == '0, "R4", "wake lasts one cycle", unit_wake, 0);
    endtask

    task automatic pulse_done(input logic [NU-1:0] m);
        unit_done = m;
        tick();
        unit_done = '0;
    endtask

    // One prefetch-side cycle with a bench queue model.
    task automatic pf_cycle(input bit spare);
        logic [NU-1:0] g;
        int lo;
        unit_pf_valid = pending;
        for (int i = 0; i < NU; i++) unit_pf_addr[i*AW +: AW] = pf_addr_of(round_no, i);
        l1_spare = spare;
        #1;
        lo = lowest(pending);
        g = (mq.size() < 16 && lo >= 0) ? (NU'(1) << lo) : '0;
        chk(unit_pf_stall == (pending & ~g), "R7", "stall vector", unit_pf_stall, pending & ~g);
        chk(pf_issue_valid == (spare && mq.size() > 0), "R8", "issue valid",
            pf_issue_valid, spare && mq.size() > 0);
        if (spare && mq.size() > 0)
            chk(pf_issue_addr == mq[0], "R8", "issue order", pf_issue_addr, mq[0]);
        tick();
        if (spare && mq.size() > 0) void'(mq.pop_front());
        if (g != '0) mq.push_back(pf_addr_of(round_no, lo));
        pending = pending & ~g;
        unit_pf_valid = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        l1_spare = 1;
        #1;
        // R1: reset state
        chk(obs_ready == 1'b1, "R1", "ready after reset", obs_ready, 1);
        chk(unit_power == '0, "R1", "power after reset", unit_power, 0);
        chk(unit_wake == '0, "R1", "wake after reset", unit_wake, 0);
        chk(pf_issue_valid == 1'b0, "R1", "queue empty", pf_issue_valid, 0);
        l1_spare = 0;
        @(negedge clk);

        // R9: program table, (3,2) left invalid
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 3; e++)
                write_tbl(r, e, !(r == 3 && e == 2), r * 16 + e + 1);

        // R3 / R4: fill the array one unit at a time
        for (int k = 0; k < NU; k++)
            offer(k % 3, (k / 3) % 3, 32'(k * 100 + 7), k, (k % 3) * 16 + (k / 3) % 3 + 1, "R3");

        // R2: all busy, observation held off
        obs_valid = 1; obs_range = 2'd1; obs_event = 2'd2; obs_data = 32'hABC;
        #1;
        chk(obs_ready == 1'b0, "R2", "ready when all busy", obs_ready, 0);
        tick();
        #1;
        chk(unit_wake == '0, "R2", "no wake when all busy", unit_wake, 0);
        chk(unit_power == '1, "R2", "power held", unit_power, 12'hFFF);

        // R6: done on units 5 and 2, held observation taken next cycle by unit 2
        unit_done = (NU'(1) << 5) | (NU'(1) << 2);
        tick();
        unit_done = '0;
        #1;
        chk(unit_power == ~((NU'(1) << 5) | (NU'(1) << 2)), "R6", "power after done",
            unit_power, ~((NU'(1) << 5) | (NU'(1) << 2)));
        chk(obs_ready == 1'b1, "R6", "ready cycle after done", obs_ready, 1);
        tick();
        obs_valid = 0;
        #1;
        chk(unit_wake == NU'(1) << 2, "R3", "lowest freed unit", unit_wake, NU'(1) << 2);
        chk(unit_entry == EW'(19), "R4", "entry (1,2)", unit_entry, 19);
        tick();
        offer(2, 0, 32'h55, 5, 33, "R3");

        // R5: discards with all units idle
        pulse_done('1);
        offer(3, 2, 32'h66, -1, 0, "R5");
        offer(0, 3, 32'h77, -1, 0, "R5");
        offer(2, 1, 32'h88, 0, 34, "R5");

        // R9: rewrite a slot invalid, then valid with new entry
        write_tbl(0, 0, 0, 16'h0);
        offer(0, 0, 32'h99, -1, 0, "R9");
        write_tbl(0, 0, 1, 16'h7E);
        offer(0, 0, 32'hAA, 1, 16'h7E, "R9");

        // R7 / R8: push arbitration and queue
        round_no = 1; pending = (NU'(1) << 3) | (NU'(1) << 7) | (NU'(1) << 9);
        for (int c = 0; c < 20 && pending != '0; c++) pf_cycle(0);
        round_no = 2; pending = '1;
        for (int c = 0; c < 20 && pending != '0; c++) pf_cycle(0);
        round_no = 3; pending = (NU'(1) << 0) | (NU'(1) << 11);
        pf_cycle(0);
        pf_cycle(0);
        for (int c = 0; c < 20 && pending != '0; c++) pf_cycle(1);
        for (int c = 0; c < 60 && mq.size() > 0; c++) pf_cycle(c % 2 == 0);
        pending = '0;
        pf_cycle(1);
        chk(mq.size() == 0, "R8", "queue drained", mq.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule